// File: doc/BRIEF.md
# Multi-Source Core Reset Sequencer

This block produces the internal reset that holds a small microcontroller core. Four requests feed it: a power-on pulse, a brown-out pulse, a watchdog expiry pulse and an external active-low clear pin. Any one of them sets a reset latch straight away, with no clock edge needed. The latch stays set while any request is present. When every request is gone and the clear pin has been seen high through a two-flop synchronizer, a delay counter clocked by the free-running on-chip RC clock begins to count. The latch is released at the counter's terminal count.

The counter is longer when a power-on event caused the reset. A sticky power-on flag selects a 10-bit span. Every other cause uses an 8-bit span. The flag is cleared when the latch releases. If any request returns while the counter is running, the counter drops to zero and waits for a fresh quiet period. The block also presents the program-counter value the core loads when reset ends: the last word of program memory.

Top module: `core_reset_seq`

## Requirements
- R1: Asserting any request (`por_req`, `bor_req`, `wdt_req` high, or `clr_n` low) drives `core_rst` high without waiting for a clock edge. `core_rst` stays high while any request is present.
- R2: `core_rst` never falls unless `clr_n` has been high on the two preceding RC clock edges. While `clr_n` is low the delay does not advance.
- R3: After a reset with no power-on event since the last release, `core_rst` falls on the 2^SHORT_W + 2 = 258th rising edge of `rc_clk` after the last request drops. This is two synchronizer edges plus 256 counting edges.
- R4: After a reset that included a power-on event, `core_rst` falls on the 2^LONG_W + 2 = 1026th rising edge after the last request drops.
- R5: The power-on flag is sticky. A brown-out, watchdog or pin request that arrives after a power-on event but before release still gives the long span. The flag is cleared at release, so a later reset without power-on uses the short span.
- R6: A request that reasserts while the delay is running restarts the full delay. That delay is counted from the new drop of the last request.
- R7: Once released, `core_rst` stays low until a new request appears.
- R8: `boot_vector` equals PMEM_WORDS-1. This is 11'h7FF for the default 2048-word memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Free-running on-chip RC clock for the delay counter |
| por_req | input | 1 | Power-on request pulse, active high |
| bor_req | input | 1 | Brown-out request pulse, active high |
| wdt_req | input | 1 | Watchdog expiry request, active high |
| clr_n | input | 1 | External clear pin, active low, asynchronous |
| core_rst | output | 1 | Internal core reset, active high |
| boot_vector | output | ADDR_W (11) | Program counter value loaded at reset release |

## Verification
The checker samples the request inputs on `rc_clk`, so it assumes each request changes away from a rising edge and lasts at least one full clock period. The bench changes every request only at falling edges and holds each for several cycles. The power-on request is treated as the checker's reset, so it is taken to be high from time zero. The bench raises it in the very first instant, and this gives the latch and the sticky flag a defined value before any property is evaluated.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int DEF_SHORT_W     = 8;
    localparam int DEF_LONG_W      = 10;
    localparam int DEF_PMEM_WORDS  = 2048;
    localparam int DEF_SYNC_STAGES = 2;

    // One bit per reset cause, each active high
    typedef struct packed {
        logic power_on;
        logic brown_out;
        logic watchdog;
        logic pin_low;
    } rst_req_t;

    typedef enum logic {
        SPAN_SHORT = 1'b0,
        SPAN_LONG  = 1'b1
    } span_e;

    function automatic logic req_active(rst_req_t r);
        return r.power_on | r.brown_out | r.watchdog | r.pin_low;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    output logic ok
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain <= 1'b0;
                else      chain <= 1'b1;
            end
        end else begin : g_multi
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain <= '0;
                else      chain <= {chain[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign ok = chain[STAGES-1];
endmodule

// File: rtl/rstseq_delay.sv
module rstseq_delay
    import rstseq_pkg::*;
#(
    parameter int SHORT_W = DEF_SHORT_W,
    parameter int LONG_W  = DEF_LONG_W
) (
    input  logic  clk,
    input  logic  clr,
    input  logic  run,
    input  span_e span,
    output logic  done
);
    localparam int               SHORT_TERM_I = (1 << SHORT_W) - 1;
    localparam logic [LONG_W-1:0] SHORT_TERM  = SHORT_TERM_I[LONG_W-1:0];
    localparam logic [LONG_W-1:0] LONG_TERM   = '1;

    logic [LONG_W-1:0] cnt;
    logic [LONG_W-1:0] term;

    always_comb begin
        term = (span == SPAN_LONG) ? LONG_TERM : SHORT_TERM;
        done = run && (cnt == term);
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr)       cnt <= '0;
        else if (done) cnt <= '0;
        else if (run)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rstseq_latch.sv
module rstseq_latch
    import rstseq_pkg::*;
(
    input  logic  clk,
    input  logic  set_any,
    input  logic  set_por,
    input  logic  release_i,
    output logic  hold,
    output span_e span
);
    logic por_seen;

    always_ff @(posedge clk or posedge set_any) begin
        if (set_any)        hold <= 1'b1;
        else if (release_i) hold <= 1'b0;
    end

    always_ff @(posedge clk or posedge set_por) begin
        if (set_por)        por_seen <= 1'b1;
        else if (release_i) por_seen <= 1'b0;
    end

    assign span = por_seen ? SPAN_LONG : SPAN_SHORT;
endmodule

// File: rtl/core_reset_seq.sv
module core_reset_seq
    import rstseq_pkg::*;
#(
    parameter int SHORT_W     = DEF_SHORT_W,
    parameter int LONG_W      = DEF_LONG_W,
    parameter int PMEM_WORDS  = DEF_PMEM_WORDS,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int ADDR_W      = $clog2(PMEM_WORDS)
) (
    input  logic              rc_clk,
    input  logic              por_req,
    input  logic              bor_req,
    input  logic              wdt_req,
    input  logic              clr_n,
    output logic              core_rst,
    output logic [ADDR_W-1:0] boot_vector
);
    localparam int TOP_ADDR_I = PMEM_WORDS - 1;

    rst_req_t req;
    logic     any_req;
    logic     pin_ok;
    logic     run;
    logic     done;
    span_e    span;

    always_comb begin
        req.power_on  = por_req;
        req.brown_out = bor_req;
        req.watchdog  = wdt_req;
        req.pin_low   = ~clr_n;
        any_req       = req_active(req);
        run           = pin_ok & core_rst;
    end

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (rc_clk),
        .arst (any_req),
        .ok   (pin_ok)
    );

    rstseq_delay #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_delay (
        .clk  (rc_clk),
        .clr  (any_req),
        .run  (run),
        .span (span),
        .done (done)
    );

    rstseq_latch u_latch (
        .clk       (rc_clk),
        .set_any   (any_req),
        .set_por   (por_req),
        .release_i (done),
        .hold      (core_rst),
        .span      (span)
    );

    assign boot_vector = TOP_ADDR_I[ADDR_W-1:0];
endmodule

// File: rtl/core_reset_seq_chk.sv
module core_reset_seq_chk #(
    parameter int SHORT_W = 8
) (
    input logic rc_clk,
    input logic por_req,
    input logic bor_req,
    input logic wdt_req,
    input logic clr_n,
    input logic core_rst
);
    localparam int MIN_QUIET = 1 << SHORT_W;

    logic     any_req;
    int       quiet;

    assign any_req = por_req | bor_req | wdt_req | ~clr_n;

    always_ff @(posedge rc_clk) begin
        if (any_req)              quiet <= 0;
        else if (quiet < 1000000) quiet <= quiet + 1;
    end

    // R1
    req_holds_reset_chk: assert property (@(posedge rc_clk) disable iff (por_req)
        any_req |-> core_rst);

    // R2
    release_needs_pin_chk: assert property (@(posedge rc_clk) disable iff (por_req)
        $fell(core_rst) |-> (clr_n && $past(clr_n)));

    // R3
    min_delay_chk: assert property (@(posedge rc_clk) disable iff (por_req)
        $fell(core_rst) |-> (quiet >= MIN_QUIET));

    // R7
    stays_released_chk: assert property (@(posedge rc_clk) disable iff (any_req)
        (!core_rst) |=> (!core_rst));
endmodule

bind core_reset_seq core_reset_seq_chk #(.SHORT_W(SHORT_W)) u_chk (
    .rc_clk   (rc_clk),
    .por_req  (por_req),
    .bor_req  (bor_req),
    .wdt_req  (wdt_req),
    .clr_n    (clr_n),
    .core_rst (core_rst)
);

// File: tb/core_reset_seq_test.sv
module core_reset_seq_test;
    localparam int CLK_P   = 10;
    localparam int SHORT_W = 8;
    localparam int LONG_W  = 10;

    logic        rc_clk = 1'b0;
    logic        por_req, bor_req, wdt_req, clr_n;
    logic        core_rst;
    logic [10:0] boot_vector;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int exp_q[$];
    bit finished = 0;

    core_reset_seq uut (
        .rc_clk      (rc_clk),
        .por_req     (por_req),
        .bor_req     (bor_req),
        .wdt_req     (wdt_req),
        .clr_n       (clr_n),
        .core_rst    (core_rst),
        .boot_vector (boot_vector)
    );

    always #(CLK_P/2) rc_clk = ~rc_clk;
    always @(posedge rc_clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Driver: raise a request set, hold it, drop it, optionally queue expected release edge
    task automatic pulse(input bit p, input bit b, input bit w, input bit pin,
                         input int hold, input bit push, input int span_w, input string req);
        @(negedge rc_clk);
        por_req = p; bor_req = b; wdt_req = w; clr_n = ~pin;
        #1;
        check(core_rst === 1'b1, "R1", int'(core_rst), 1);
        repeat (hold) @(negedge rc_clk);
        check(core_rst === 1'b1, "R1", int'(core_rst), 1);
        por_req = 0; bor_req = 0; wdt_req = 0; clr_n = 1;
        if (push) exp_q.push_back(cyc + 2 + (1 << span_w));
        if (push) $display("info: %s expects release at edge %0d", req, cyc + 2 + (1 << span_w));
    endtask

    task automatic wait_release();
        while (core_rst !== 1'b0) @(negedge rc_clk);
        repeat (20) begin
            @(negedge rc_clk);
            check(core_rst === 1'b0, "R7", int'(core_rst), 0);
        end
    endtask

    // Monitor: pop expected release edge on every falling core_rst
    initial begin
        logic prev;
        prev = 1'b1;
        forever begin
            @(negedge rc_clk);
            if (prev === 1'b1 && core_rst === 1'b0) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6 unexpected release", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(cyc == e, "R3/R4/R5/R6 release edge", cyc, e);
                end
            end
            prev = core_rst;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            check(0, "watchdog", 0, 1);
            summary();
        end
    end

    initial begin
        por_req = 1; bor_req = 0; wdt_req = 0; clr_n = 0;
        repeat (3) @(negedge rc_clk);
        check(core_rst === 1'b1, "R1 reset state", int'(core_rst), 1);
        // R8
        check(boot_vector == 11'h7FF, "R8", int'(boot_vector), 'h7FF);
        // R2: power-on drops but pin held low, no release
        por_req = 0;
        repeat (300) @(negedge rc_clk);
        check(core_rst === 1'b1, "R2", int'(core_rst), 1);
        clr_n = 1;
        exp_q.push_back(cyc + 2 + (1 << LONG_W));   // R4
        wait_release();

        pulse(0, 1, 0, 0, 3, 1, SHORT_W, "R3 brown-out");
        wait_release();
        pulse(0, 0, 1, 0, 2, 1, SHORT_W, "R3 watchdog");
        wait_release();
        pulse(0, 0, 0, 1, 5, 1, SHORT_W, "R3 pin");
        wait_release();

        // R5 + R6: power-on, then brown-out mid-count keeps long span
        pulse(1, 0, 0, 0, 2, 0, LONG_W, "R5 por");
        repeat (500) @(negedge rc_clk);
        check(core_rst === 1'b1, "R6", int'(core_rst), 1);
        pulse(0, 1, 0, 0, 2, 1, LONG_W, "R5 sticky");
        wait_release();

        // R5: flag cleared, next reset is short
        pulse(0, 0, 1, 0, 2, 1, SHORT_W, "R5 cleared");
        wait_release();

        // R6: pin pulled low mid-count restarts the short delay
        pulse(0, 0, 1, 0, 2, 0, SHORT_W, "R6 first");
        repeat (200) @(negedge rc_clk);
        check(core_rst === 1'b1, "R6", int'(core_rst), 1);
        pulse(0, 0, 0, 1, 4, 1, SHORT_W, "R6 restart");
        wait_release();

        check(exp_q.size() == 0, "R6 pending", exp_q.size(), 0);
        finished = 1;
        summary();
    end
endmodule